// File: doc/BRIEF.md
# Double-Write Confirmed Control Register Bank

This block holds the byte-wide control registers of two signal-processing channels (called canceller A and canceller B) behind a plain synchronous host bus made of a strobe, a write flag, an address and a data byte. The register contents are driven out continuously as static control outputs. Each canceller owns two registers: a mode register and a second configuration register. At reset, every mode register is 0x00 and every configuration register is 0x02.

Canceller A's registers accept a single write. Canceller B's two registers are protected. A value lands only when the host writes the same address a second time, and no other write may fall between the two. The spacing of the two writes must also lie inside a time window of at least 350 ns and at most 20 us. The window is counted in clock cycles derived from a clock-frequency parameter. Reserved bits are forced to their fixed values. Bit 7 of a mode register acts as a self-clearing soft reset: committing it restores that canceller's pair of registers to their defaults and raises a one-cycle coefficient-clear pulse for that canceller.

Top module: `ec_ctl_bank`

## Requirements
- R1: After reset, ca_cfg1 and cb_cfg1 are 0x00, ca_cfg2 and cb_cfg2 are 0x02, bus_rdata is 0x00 and coef_clr is 2'b00.
- R2: A write to offset 0x00 (A mode) or 0x01 (A config) commits on that single write. The new value is on the output port the cycle after the strobe and is returned by a later read.
- R3: A write to offset 0x20 (B mode) or 0x21 (B config) commits only if the previous write strobe went to the same address and the gap G in clock cycles between the two strobes satisfies MIN <= G <= MAX. The committed value is the second write's data. MIN = ceil(350 ns x f) and MAX = floor(20 us x f), which gives 70 and 4000 at 200 MHz.
- R4: A lone first write to a protected address leaves the register and its read value at the previously committed value.
- R5: A repeat write to the same protected address with G < MIN does not commit. That write becomes a new first write, so a further write MIN cycles after it commits.
- R6: A repeat write with G > MAX does not commit. That write becomes a new first write.
- R7: Any write to another address between the two writes cancels the pending write. Reads do not cancel it.
- R8: Bit 1 of ca_cfg2 and cb_cfg2 always reads 1. Bit 0 of cb_cfg1 always reads 0, whatever data is written.
- R9: A committed mode-register write with bit 7 set returns both registers of that canceller to 0x00 and 0x02, so bit 7 never reads back as 1. It also raises coef_clr[0] (A) or coef_clr[1] (B) for exactly the cycle after the write. The other canceller is untouched.
- R10: A read (strobe with write flag low) presents the register value on bus_rdata the cycle after the strobe. Unmapped offsets read 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_stb | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| ca_cfg1 | output | 8 | Canceller A mode register |
| ca_cfg2 | output | 8 | Canceller A configuration register |
| cb_cfg1 | output | 8 | Canceller B mode register |
| cb_cfg2 | output | 8 | Canceller B configuration register |
| coef_clr | output | 2 | One-cycle coefficient-clear pulse per canceller |

## Verification
The hardest cases to reach are the window edges: a repeat write exactly MIN-1, MIN, MAX or MAX+1 cycles after the first. Random traffic almost never lands on these by chance. Directed sequences pad the gap with counted idle cycles, and the count includes the cycle taken by any interleaved read, so each edge is hit exactly. The random phase favours reusing the previous address and draws some gaps close to each limit. This lets expiry, early repeats and intervening writes chain into one another.

// File: rtl/ecreg_pkg.sv
`timescale 1ns/1ps
package ecreg_pkg;
    localparam int AW       = 8;
    localparam int DW       = 8;
    localparam int NCAN     = 2;
    localparam int REGS_PER = 2;
    localparam int NREG     = NCAN * REGS_PER;
    localparam int STRIDE   = 32;
    localparam int SRST_BIT = 7;

    typedef logic [AW-1:0] addr_t;
    typedef logic [DW-1:0] byte_t;

    typedef enum logic {G_IDLE, G_ARMED} guard_e;

    typedef struct packed {
        addr_t addr;
        byte_t dflt;
        byte_t set1;
        byte_t clr0;
        logic  prot;
    } reg_attr_t;

    function automatic reg_attr_t reg_attr(int i);
        reg_attr_t a;
        int can;
        int sub;
        can    = i / REGS_PER;
        sub    = i % REGS_PER;
        a.addr = addr_t'(can * STRIDE + sub);
        a.dflt = (sub == 1) ? byte_t'(8'h02) : byte_t'(8'h00);
        a.set1 = (sub == 1) ? byte_t'(8'h02) : byte_t'(8'h00);
        a.clr0 = (sub == 0 && can == 1) ? byte_t'(8'h01) : byte_t'(8'h00);
        a.prot = (can == 1);
        return a;
    endfunction
endpackage

// File: rtl/ecreg_dwguard.sv
`timescale 1ns/1ps
module ecreg_dwguard
    import ecreg_pkg::*;
#(
    parameter int MIN_CYC = 70,
    parameter int MAX_CYC = 4000
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_stb,
    input  addr_t wr_addr,
    input  logic  prot_hit,
    output logic  ok
);
    localparam int CW = $clog2(MAX_CYC + 1);
    localparam logic [CW-1:0] MIN_C = CW'(MIN_CYC);
    localparam logic [CW-1:0] MAX_C = CW'(MAX_CYC);
    localparam logic [CW-1:0] ONE   = CW'(1);

    guard_e         st;
    addr_t          pend;
    logic [CW-1:0]  cnt;

    assign ok = wr_stb && prot_hit && (st == G_ARMED) && (wr_addr == pend) && (cnt >= MIN_C);

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= G_IDLE;
            pend <= '0;
            cnt  <= '0;
        end else if (wr_stb) begin
            if (ok) begin
                st  <= G_IDLE;
                cnt <= '0;
            end else if (prot_hit) begin
                st   <= G_ARMED;
                pend <= wr_addr;
                cnt  <= ONE;
            end else begin
                st  <= G_IDLE;
                cnt <= '0;
            end
        end else if (st == G_ARMED) begin
            if (cnt == MAX_C) begin
                st  <= G_IDLE;
                cnt <= '0;
            end else begin
                cnt <= cnt + ONE;
            end
        end
    end

    // gap counter stays inside [1, MAX] while a first write is pending
    assert_window_bounds_R3: assert property (@(posedge clk) disable iff (rst)
        (st == G_ARMED) |-> (cnt >= ONE && cnt <= MAX_C));

    // an expired window drops the pending write before any overrun
    assert_expire_R6: assert property (@(posedge clk) disable iff (rst)
        (st == G_ARMED && cnt == MAX_C && !wr_stb) |=> (st == G_IDLE));
endmodule

// File: rtl/ecreg_cell.sv
`timescale 1ns/1ps
module ecreg_cell
    import ecreg_pkg::*;
#(
    parameter int IDX = 0
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  we,
    input  logic  init,
    input  byte_t wdata,
    output byte_t q
);
    localparam reg_attr_t ATTR = reg_attr(IDX);

    always_ff @(posedge clk) begin
        if (rst || init) begin
            q <= ATTR.dflt;
        end else if (we) begin
            q <= (wdata & ~ATTR.clr0) | ATTR.set1;
        end
    end

    assert_reserved_R8: assert property (@(posedge clk) disable iff (rst)
        ((q & ATTR.clr0) == '0) && ((q & ATTR.set1) == ATTR.set1));
endmodule

// File: rtl/ec_ctl_bank.sv
`timescale 1ns/1ps
module ec_ctl_bank
    import ecreg_pkg::*;
#(
    parameter int CLK_MHZ    = 200,
    parameter int MIN_GAP_NS = 350,
    parameter int MAX_GAP_NS = 20000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_stb,
    input  logic        bus_we,
    input  logic [7:0]  bus_addr,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    output logic [7:0]  ca_cfg1,
    output logic [7:0]  ca_cfg2,
    output logic [7:0]  cb_cfg1,
    output logic [7:0]  cb_cfg2,
    output logic [1:0]  coef_clr
);
    localparam int MIN_CYC = (MIN_GAP_NS * CLK_MHZ + 999) / 1000;
    localparam int MAX_CYC = (MAX_GAP_NS * CLK_MHZ) / 1000;

    byte_t             q [NREG];
    logic [NREG-1:0]   sel;
    logic [NREG-1:0]   commit;
    logic [NCAN-1:0]   init;
    logic [NCAN-1:0]   clr_q;
    logic              wr_stb;
    logic              prot_hit;
    logic              guard_ok;
    byte_t             rd_mux;

    assign wr_stb = bus_stb && bus_we;

    always_comb begin
        prot_hit = 1'b0;
        for (int i = 0; i < NREG; i++) begin
            sel[i] = wr_stb && (bus_addr == reg_attr(i).addr);
            if (sel[i] && reg_attr(i).prot) prot_hit = 1'b1;
        end
    end

    ecreg_dwguard #(.MIN_CYC(MIN_CYC), .MAX_CYC(MAX_CYC)) u_guard (
        .clk      (clk),
        .rst      (rst),
        .wr_stb   (wr_stb),
        .wr_addr  (bus_addr),
        .prot_hit (prot_hit),
        .ok       (guard_ok)
    );

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        localparam reg_attr_t A = reg_attr(i);
        if (A.prot) begin : g_prot
            assign commit[i] = sel[i] && guard_ok;
        end else begin : g_open
            assign commit[i] = sel[i];
        end
        ecreg_cell #(.IDX(i)) u_cell (
            .clk   (clk),
            .rst   (rst),
            .we    (commit[i]),
            .init  (init[i / REGS_PER]),
            .wdata (bus_wdata),
            .q     (q[i])
        );
    end

    for (genvar c = 0; c < NCAN; c++) begin : g_can
        assign init[c] = commit[c * REGS_PER] && bus_wdata[SRST_BIT];
    end

    always_ff @(posedge clk) begin
        if (rst) clr_q <= '0;
        else     clr_q <= init;
    end

    always_comb begin
        rd_mux = '0;
        for (int i = 0; i < NREG; i++) begin
            if (bus_addr == reg_attr(i).addr) rd_mux = q[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                     bus_rdata <= '0;
        else if (bus_stb && !bus_we) bus_rdata <= rd_mux;
    end

    assign ca_cfg1  = q[0];
    assign ca_cfg2  = q[1];
    assign cb_cfg1  = q[2];
    assign cb_cfg2  = q[3];
    assign coef_clr = clr_q;

    // protected registers change only on a confirmed write or a soft reset
    for (genvar i = 0; i < NREG; i++) begin : g_chk
        localparam reg_attr_t B = reg_attr(i);
        if (B.prot) begin : g_p
            assert_prot_commit_R4: assert property (@(posedge clk) disable iff (rst)
                ($past(!rst) && !$past(init[i / REGS_PER]) && (q[i] != $past(q[i])))
                    |-> $past(guard_ok));
        end
    end

    // a clear pulse coincides with the owner's registers at default values
    for (genvar c = 0; c < NCAN; c++) begin : g_clr
        assert_clear_defaults_R9: assert property (@(posedge clk) disable iff (rst)
            coef_clr[c] |-> (q[c * REGS_PER] == reg_attr(c * REGS_PER).dflt &&
                             q[c * REGS_PER + 1] == reg_attr(c * REGS_PER + 1).dflt));
    end
endmodule

// File: tb/test_ec_ctl_bank.sv
`timescale 1ns/1ps
module test_ec_ctl_bank;
    // 350 ns and 20 us at 200 MHz
    localparam int MINC = 70;
    localparam int MAXC = 4000;

    logic       clk = 1'b0;
    logic       rst;
    logic       stb, we;
    logic [7:0] addr, wdata;
    logic [7:0] rdata, ca1, ca2, cb1, cb2;
    logic [1:0] clr;

    always #2.5 clk = ~clk;

    ec_ctl_bank i_ec_ctl_bank (
        .clk(clk), .rst(rst), .bus_stb(stb), .bus_we(we), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata), .ca_cfg1(ca1), .ca_cfg2(ca2),
        .cb_cfg1(cb1), .cb_cfg2(cb2), .coef_clr(clr)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int   n_chk = 0, n_bad = 0;
    bit   done = 0;
    logic [7:0] mdl [4];
    logic [1:0] mclr;
    bit   pend;
    logic [7:0] paddr;
    int   pt;

    function automatic int idx_of(logic [7:0] a);
        case (a)
            8'h00: return 0;
            8'h01: return 1;
            8'h20: return 2;
            8'h21: return 3;
            default: return -1;
        endcase
    endfunction

    function automatic logic [7:0] dflt(int i);
        return (i == 1 || i == 3) ? 8'h02 : 8'h00;
    endfunction

    function automatic logic [7:0] fixb(int i, logic [7:0] d);
        logic [7:0] r;
        r = d;
        if (i == 1 || i == 3) r = r | 8'h02;
        if (i == 2) r = r & 8'hFE;
        return r;
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic cmp_outs(string tag);
        chk(ca1 == mdl[0], {tag, " ca_cfg1"}, ca1, mdl[0]);
        chk(ca2 == mdl[1], {tag, " ca_cfg2"}, ca2, mdl[1]);
        chk(cb1 == mdl[2], {tag, " cb_cfg1"}, cb1, mdl[2]);
        chk(cb2 == mdl[3], {tag, " cb_cfg2"}, cb2, mdl[3]);
        chk(clr == mclr,   {tag, " coef_clr"}, clr, mclr);
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
        mclr = '0;
    endtask

    task automatic commit(int i, logic [7:0] d);
        int c;
        if (i % 2 == 0 && d[7]) begin
            c = i / 2;
            mdl[2*c]   = dflt(2*c);
            mdl[2*c+1] = dflt(2*c+1);
            mclr[c]    = 1'b1;
        end else begin
            mdl[i] = fixb(i, d);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d, string tag);
        int i, t;
        stb = 1; we = 1; addr = a; wdata = d; t = cyc;
        @(negedge clk);
        stb = 0; we = 0;
        mclr = '0;
        i = idx_of(a);
        if (i < 0) begin
            pend = 0;
        end else if (i >= 2) begin
            if (pend && paddr == a && (t - pt) >= MINC && (t - pt) <= MAXC) begin
                pend = 0;
                commit(i, d);
            end else begin
                pend = 1; paddr = a; pt = t;
            end
        end else begin
            pend = 0;
            commit(i, d);
        end
        cmp_outs(tag);
        mclr = '0;
    endtask

    task automatic rd(logic [7:0] a, string tag);
        int i;
        logic [7:0] e;
        stb = 1; we = 0; addr = a;
        @(negedge clk);
        stb = 0;
        mclr = '0;
        i = idx_of(a);
        e = (i < 0) ? 8'h00 : mdl[i];
        chk(rdata == e, {tag, " rdata"}, rdata, e);
        cmp_outs(tag);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog R1..all: got 0x0 expected 0x1");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        stb = 0; we = 0; addr = 0; wdata = 0; rst = 1;
        for (int i = 0; i < 4; i++) mdl[i] = dflt(i);
        mclr = '0; pend = 0; paddr = 0; pt = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk(rdata == 8'h00, "R1 rdata", rdata, 0);
        cmp_outs("R1");
        rd(8'h21, "R10 read B config default");
        rd(8'h05, "R10 unmapped");

        // R2 single write
        wr(8'h00, 8'h5A, "R2");
        chk(ca1 == 8'h5A, "R2 direct", ca1, 8'h5A);
        rd(8'h00, "R2 readback");

        // R4 lone write, read between does not cancel (R7), exact MIN gap (R3)
        wr(8'h20, 8'h44, "R4");
        chk(cb1 == 8'h00, "R4 lone write", cb1, 0);
        rd(8'h20, "R4 read pending");
        idle(MINC - 2);
        wr(8'h20, 8'h44, "R3 min gap");
        chk(cb1 == 8'h44, "R3 min gap commit", cb1, 8'h44);

        // R3 exact MAX gap
        wr(8'h21, 8'h30, "R3");
        idle(MAXC - 1);
        wr(8'h21, 8'h31, "R3 max gap");
        chk(cb2 == 8'h33, "R3 max gap commit", cb2, 8'h33);

        // R5 too early, then re-armed
        wr(8'h20, 8'h11, "R5");
        idle(MINC - 2);
        wr(8'h20, 8'h11, "R5 early");
        chk(cb1 == 8'h44, "R5 early no commit", cb1, 8'h44);
        idle(MINC - 1);
        wr(8'h20, 8'h12, "R5 rearm");
        chk(cb1 == 8'h12, "R5 rearm commit", cb1, 8'h12);

        // R6 too late, then re-armed
        wr(8'h21, 8'h08, "R6");
        idle(MAXC);
        wr(8'h21, 8'h08, "R6 late");
        chk(cb2 == 8'h33, "R6 late no commit", cb2, 8'h33);
        idle(MINC + 9);
        wr(8'h21, 8'h0C, "R6 rearm");
        chk(cb2 == 8'h0E, "R6 rearm commit", cb2, 8'h0E);

        // R7 intervening write cancels; R8 forced bit in A config
        wr(8'h20, 8'h21, "R7");
        idle(MINC);
        wr(8'h01, 8'h00, "R7 other addr");
        chk(ca2 == 8'h02, "R8 A config bit1", ca2, 8'h02);
        wr(8'h20, 8'h21, "R7 after cancel");
        chk(cb1 == 8'h12, "R7 cancelled", cb1, 8'h12);

        // R8 reserved bit 0 of B mode
        wr(8'h20, 8'h7F, "R8");
        idle(MINC - 1);
        wr(8'h20, 8'h7F, "R8 commit");
        chk(cb1 == 8'h7E, "R8 B mode bit0", cb1, 8'h7E);

        // R9 soft reset A
        wr(8'h01, 8'h3C, "R9 setup");
        wr(8'h00, 8'h80, "R9 A reset");
        chk(ca1 == 8'h00 && ca2 == 8'h02, "R9 A defaults", {ca1, ca2}, 16'h0002);
        chk(clr == 2'b01, "R9 A pulse", clr, 1);
        chk(cb1 == 8'h7E, "R9 B untouched", cb1, 8'h7E);
        idle(1);
        chk(clr == 2'b00, "R9 pulse one cycle", clr, 0);
        // R9 soft reset B through double write
        wr(8'h01, 8'h55, "R9 setup2");
        wr(8'h20, 8'h80, "R9 B first");
        idle(MINC - 1);
        wr(8'h20, 8'h80, "R9 B reset");
        chk(cb1 == 8'h00 && cb2 == 8'h02, "R9 B defaults", {cb1, cb2}, 16'h0002);
        chk(clr == 2'b10, "R9 B pulse", clr, 2);
        chk(ca2 == 8'h57, "R9 A untouched", ca2, 8'h57);
        rd(8'h20, "R10 read after reset");

        // random phase
        begin
            logic [7:0] alist [8] = '{8'h00, 8'h01, 8'h20, 8'h21, 8'h20, 8'h21, 8'h07, 8'h40};
            logic [7:0] la;
            la = 8'h20;
            for (int k = 0; k < 250; k++) begin
                logic [7:0] a, d;
                int g;
                a = ($urandom % 2 == 0) ? la : alist[$urandom % 8];
                d = 8'($urandom);
                if ($urandom % 8 != 0) d[7] = 1'b0;
                if ($urandom % 4 == 0) rd(a, "R10 random read");
                else                   wr(a, d, "R3 random write");
                la = a;
                g = $urandom % 20;
                if (g < 12)       idle($urandom % 4);
                else if (g < 18)  idle(MINC - 3 + ($urandom % 4));
                else if (g == 18) idle(MAXC - 2 + ($urandom % 3));
                else              idle(1000);
            end
        end

        done = 1;
        summary();
        $finish;
    end
endmodule